// File: doc/BRIEF.md
# Glitch-free clock source switch

This block chooses the system clock from two sources that are unrelated in phase and frequency: a master clock input and the output of a frequency synthesiser. A select input names the wanted source. When the select changes, the block closes the gate of the outgoing source on that source's falling edge. It then waits for the closure to pass through a synchroniser in the incoming domain, and opens the incoming gate on the incoming source's falling edge. The output therefore sits low for the whole handover and never carries a partial pulse.

The normal handover needs the outgoing clock to keep toggling, because its gate can only close on one of its own edges. A force input covers the case where the outgoing source has already been stopped. While force is high, the gate of the source that is not selected is cleared without waiting for a clock edge, so the incoming side can proceed. A two-bit status output shows which gate is open at any moment.

Top module: `clk_src_switch`

## Requirements
- R1: The select encodes 0 = master clock, 1 = synthesiser clock. After reset with select 0, src_o becomes 2'b01 within SYNC_STAGES+2 master-clock cycles and clk_o then follows the master clock.
- R2: While rst_i is high (held for at least SYNC_STAGES+2 cycles of each running source), src_o is 2'b00 and clk_o is low.
- R3: src_o bit 0 (master gate open) and bit 1 (synthesiser gate open) are never both set.
- R4: The incoming gate opens only after the outgoing gate has closed, and clk_o never goes high while src_o is 2'b00.
- R5: Both gates change only while their own source clock is low. As a result, no high or low phase of clk_o is shorter than the shorter of the two source half-periods.
- R6: With force_i low, if the current source stops, a change of select does not complete: src_o keeps its old bit and clk_o stays low.
- R7: With force_i high, a change of select completes even when the outgoing source has stopped, and the gate of the unselected source is held closed without any edge of that source.
- R8: With both sources running, a change of select completes within SYNC_STAGES+2 cycles of the outgoing clock plus SYNC_STAGES+2 cycles of the incoming clock.
- R9: Switching from the synthesiser back to the master clock behaves in the same way as the forward direction, and clk_o then follows the master clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock source |
| pll_i | input | 1 | Synthesiser clock source |
| rst_i | input | 1 | Active-high reset, sampled by each source clock |
| sel_i | input | 1 | Wanted source: 0 master, 1 synthesiser |
| force_i | input | 1 | Allow handover when the outgoing source has stopped |
| clk_o | output | 1 | Switched clock |
| src_o | output | 2 | Open gate: bit 0 master, bit 1 synthesiser |

## Verification
On every edge of each source clock, the assertions check that at most one gate is open and that a gate only opens once the other gate was already closed one edge earlier. They also check that force holds the unselected master gate shut, and that reset closes each gate. The bench scenarios cover the rest. They show the switch stalling when the current source is stopped without force and completing once force is raised. They show the handover finishing within its cycle bound in both directions. A timing monitor on clk_o shows that no phase is ever shorter than the fastest source half-period.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
  localparam int NUM_SRC = 2;
  typedef enum logic [0:0] {
    SRC_MCLK = 1'b0,
    SRC_PLL  = 1'b1
  } src_e;
endpackage

// File: rtl/csw_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser with synchronous reset and an asynchronous clear.
module csw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge clr) begin
    if (clr)      chain <= '0;
    else if (rst) chain <= '0;
    else          chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/csw_gate.sv
`timescale 1ns/1ps
// One source branch: synchronised request, falling-edge enable, AND gate.
module csw_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic clr,
  input  logic rst,
  input  logic want,
  output logic en,
  output logic clk_g
);
  logic want_s;

  csw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk_src),
    .clr (clr),
    .rst (rst),
    .d   (want),
    .q   (want_s)
  );

  // Enable changes only while clk_src is low, so the AND never chops a phase.
  always_ff @(negedge clk_src or posedge clr) begin
    if (clr)      en <= 1'b0;
    else if (rst) en <= 1'b0;
    else          en <= want_s;
  end

  assign clk_g = clk_src & en;
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch
  import csw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk_i,
  input  logic       pll_i,
  input  logic       rst_i,
  input  logic       sel_i,
  input  logic       force_i,
  output logic       clk_o,
  output logic [1:0] src_o
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] clk_g;
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] clr;

  assign src_clk[SRC_MCLK] = mclk_i;
  assign src_clk[SRC_PLL]  = pll_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_branch
    localparam int OTHER = NUM_SRC - 1 - i;
    logic picked;
    assign picked  = (sel_i == 1'(i));
    // Request only once the other gate is seen closed (break before make).
    assign want[i] = picked & ~en[OTHER];
    // Force: close an unselected gate without waiting on its clock.
    assign clr[i]  = force_i & ~picked;

    csw_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_src (src_clk[i]),
      .clr     (clr[i]),
      .rst     (rst_i),
      .want    (want[i]),
      .en      (en[i]),
      .clk_g   (clk_g[i])
    );
  end

  assign clk_o = |clk_g;
  assign src_o = en;
endmodule

// File: rtl/csw_checker.sv
`timescale 1ns/1ps
module csw_checker (
  input logic       mclk_i,
  input logic       pll_i,
  input logic       rst_i,
  input logic       sel_i,
  input logic       force_i,
  input logic [1:0] src_o
);
  logic [1:0] m_cnt = '0;
  logic [1:0] p_cnt = '0;
  always_ff @(posedge mclk_i) if (m_cnt != 2'd3) m_cnt <= m_cnt + 2'd1;
  always_ff @(posedge pll_i)  if (p_cnt != 2'd3) p_cnt <= p_cnt + 2'd1;

  a_r3_one_gate_m: assert property (@(posedge mclk_i) disable iff (rst_i) $onehot0(src_o));
  a_r3_one_gate_p: assert property (@(posedge pll_i)  disable iff (rst_i) $onehot0(src_o));

  a_r4_bbm_to_pll: assert property (@(posedge pll_i) disable iff (rst_i)
    $rose(src_o[1]) |-> $past(!src_o[0]));
  a_r4_bbm_to_mclk: assert property (@(posedge mclk_i) disable iff (rst_i)
    $rose(src_o[0]) |-> $past(!src_o[1]));

  a_r7_force_shut: assert property (@(posedge pll_i) disable iff (rst_i)
    (force_i && sel_i) |-> !src_o[0]);

  a_r2_reset_m: assert property (@(posedge mclk_i)
    (m_cnt == 2'd3 && $past(rst_i)) |-> !src_o[0]);
  a_r2_reset_p: assert property (@(posedge pll_i)
    (p_cnt == 2'd3 && $past(rst_i)) |-> !src_o[1]);
endmodule

bind clk_src_switch csw_checker u_chk (
  .mclk_i  (mclk_i),
  .pll_i   (pll_i),
  .rst_i   (rst_i),
  .sel_i   (sel_i),
  .force_i (force_i),
  .src_o   (src_o)
);

// File: tb/clk_src_switch_bench.sv
`timescale 1ns/1ps
module clk_src_switch_bench;
  logic mclk = 1'b0, pll = 1'b0;
  logic mclk_run = 1'b1, pll_run = 1'b1;
  logic rst = 1'b1, sel = 1'b0, frc = 1'b0;
  logic clk_o;
  logic [1:0] src_o;
  int total = 0, bad = 0;
  bit finished = 0;

  clk_src_switch u_clk_src_switch (
    .mclk_i (mclk), .pll_i (pll), .rst_i (rst), .sel_i (sel),
    .force_i (frc), .clk_o (clk_o), .src_o (src_o)
  );

  // 200 MHz master clock, 7 ns synthesiser clock; stopping parks them low.
  always #2.5 mclk = mclk_run ? ~mclk : 1'b0;
  always #3.5 pll  = pll_run  ? ~pll  : 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Scoreboard: driver pushes expected status, monitor pops and compares.
  typedef struct { logic [1:0] src; string req; } item_t;
  item_t sb_q[$];

  task automatic expect_src(input logic [1:0] s, input string req);
    item_t it;
    it.src = s; it.req = req;
    sb_q.push_back(it);
    #1;
  endtask

  initial forever begin
    item_t it;
    wait (sb_q.size() != 0);
    it = sb_q.pop_front();
    chk(src_o === it.src, it.req, "src_o", 32'(src_o), 32'(it.src));
  end

  // Glitch and handover monitors (R4, R5): shortest phase 2.5 ns.
  realtime t_last = 0;
  int short_ph = 0, edges = 0, hi_idle = 0;
  always @(clk_o) begin
    if (!rst && t_last > 0 && ($realtime - t_last) < 2.4) short_ph++;
    t_last = $realtime;
    edges++;
  end
  always @(posedge clk_o) if (!rst && src_o == 2'b00) hi_idle++;

  task automatic follow(input bit use_pll, input string req);
    if (!use_pll) begin
      @(posedge mclk); #0.4; chk(clk_o === 1'b1, req, "clk_o high with mclk", 32'(clk_o), 1);
      @(negedge mclk); #0.4; chk(clk_o === 1'b0, req, "clk_o low with mclk", 32'(clk_o), 0);
    end else begin
      @(posedge pll);  #0.4; chk(clk_o === 1'b1, req, "clk_o high with pll", 32'(clk_o), 1);
      @(negedge pll);  #0.4; chk(clk_o === 1'b0, req, "clk_o low with pll", 32'(clk_o), 0);
    end
  endtask

  task automatic stays_low(input string req);
    bit hi = 0;
    for (int k = 0; k < 20; k++) begin #1.3; if (clk_o !== 1'b0) hi = 1; end
    chk(!hi, req, "clk_o stuck low", 32'(hi), 0);
  endtask

  initial begin
    #0.2;
    #100;
    expect_src(2'b00, "R2");
    stays_low("R2");
    rst = 1'b0;
    #40;
    expect_src(2'b01, "R1");
    follow(1'b0, "R1");
    // forward switch, bound 20 ns + 28 ns
    sel = 1'b1;
    #55;
    expect_src(2'b10, "R8");
    follow(1'b1, "R8");
    // back to master clock
    sel = 1'b0;
    #55;
    expect_src(2'b01, "R9");
    follow(1'b0, "R9");
    // stop master, no force: must stall
    mclk_run = 1'b0;
    #20;
    sel = 1'b1;
    #200;
    expect_src(2'b01, "R6");
    stays_low("R6");
    // raise force: completes with master stopped
    frc = 1'b1;
    #60;
    expect_src(2'b10, "R7");
    follow(1'b1, "R7");
    // restart master, drop force, switch back normally
    mclk_run = 1'b1;
    frc = 1'b0;
    #30;
    expect_src(2'b10, "R7");
    sel = 1'b0;
    #55;
    expect_src(2'b01, "R9");
    follow(1'b0, "R9");
    // forced switch with synthesiser stopped
    sel = 1'b1;
    #55;
    expect_src(2'b10, "R8");
    pll_run = 1'b0;
    #20;
    frc = 1'b1;
    sel = 1'b0;
    #40;
    expect_src(2'b00 | 2'b01, "R7");
    follow(1'b0, "R7");
    #10;
    chk(short_ph == 0, "R5", "short phases on clk_o", 32'(short_ph), 0);
    chk(edges > 20, "R5", "clk_o edges seen", 32'(edges), 21);
    chk(hi_idle == 0, "R4", "clk_o high during handover", 32'(hi_idle), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule